// File: doc/BRIEF.md
# Serial Flash Protect-Update and Byte-Read Sequencer

This block is the host side of a four-wire serial link to a configuration flash. A write request carries a new protection byte. The block enables writes on the flash, sends the byte into the status register, and then reads the status back again and again until the flash reports that its internal write cycle has ended. It finishes with a done pulse, or with an error pulse if the flash stays busy for longer than the allowed bound.

A read request carries a 24-bit address. The block returns the byte stored there with a one-cycle valid strobe.

The serial clock comes from the system clock through a divider. The divider ratio is derived from parameters, so the link never runs faster than the flash allows during reads.

Top module: `sf_status_seq`

## Requirements
- R1: A write request produces three kinds of chip-select frame, in this order. First a frame holding only opcode 0x06. Then a frame holding opcode 0x01 followed by the requested byte. Then one or more frames of opcode 0x05. All bits are sent most significant bit first.
- R2: The status-write frame lasts exactly 16 serial clock rising edges. Chip select goes high right after the eighth data bit, with no further clock pulse.
- R3: Each status-poll frame lasts 16 rising edges. The block polls again while status bit 0 (write in progress) reads 1. When it reads 0, the block raises `wr_done` for one cycle, and `wr_err` stays low.
- R4: If bit 0 still reads 1 once `TMO_CYC` system cycles of polling have passed, the block stops and raises `wr_err` for one cycle instead of `wr_done`.
- R5: A read request sends opcode 0x03 and then the 24-bit address, most significant bit first, over 40 rising edges. The eight bits sampled on the last eight rising edges, MSB first, appear on `rd_data` together with a one-cycle `rd_valid`.
- R6: Each serial clock phase lasts HALF = ceil(SYS_HZ / (2*SCK_MAX_HZ)) system cycles. With the defaults, rising edges are 8 cycles apart.
- R7: The serial clock is low whenever chip select is high. Between two frames of one sequence, chip select stays high for at least 2*HALF system cycles.
- R8: `busy` is high from the cycle after a request is accepted until the final pulse. Requests that arrive while busy are ignored. When both requests arrive in the same idle cycle, the write is taken and the read is dropped.
- R9: After reset: chip select high, serial clock low, and `busy`, `wr_done`, `wr_err` and `rd_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_start | input | 1 | Start the protect-byte update |
| wr_value | input | 8 | Byte to place in the status register |
| rd_start | input | 1 | Start a single-byte read |
| rd_addr | input | 24 | Read address |
| busy | output | 1 | A sequence is running |
| wr_done | output | 1 | Update confirmed (one-cycle pulse) |
| wr_err | output | 1 | Update timed out (one-cycle pulse) |
| rd_valid | output | 1 | `rd_data` is new (one-cycle pulse) |
| rd_data | output | 8 | Byte returned by the last read |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A wrong command-step register shows up within one frame. The flash model records every chip-select window, so the bench sees a wrong opcode, a wrong bit count or a wrong frame order as soon as chip select rises.

A bad bit counter or divider changes the spacing of rising edges. Edge spacing is checked on every edge, so the fault appears within a few system cycles.

Faults in the poll decision or the timeout counter appear only at the end of a sequence. They show as a wrong number of poll frames, or as the wrong pulse of done or error.

// File: rtl/sf_status_seq.sv
module sf_status_seq #(
  parameter int SYS_HZ     = 125_000_000,
  parameter int SCK_MAX_HZ = 20_000_000,
  parameter int TMO_CYC    = SYS_HZ / 1000 * 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic [7:0]  wr_value,
  input  logic        rd_start,
  input  logic [23:0] rd_addr,
  output logic        busy,
  output logic        wr_done,
  output logic        wr_err,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam int HALF = (SYS_HZ + 2 * SCK_MAX_HZ - 1) / (2 * SCK_MAX_HZ);
  localparam int CW   = $clog2(2 * HALF + 1);
  localparam int TW   = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_t;
  typedef enum logic [1:0] {C_WREN, C_WRSR, C_RDSR, C_READ} cmd_t;
  localparam logic [1:0] EV_NONE = 2'd0, EV_DONE = 2'd1, EV_ERR = 2'd2, EV_RD = 2'd3;

  st_t         st;
  cmd_t        cmd, nxt;
  logic        more;
  logic [1:0]  ev;
  logic [CW-1:0] cnt;
  logic [5:0]  bits;
  logic [39:0] tx;
  logic [7:0]  rx, wval;
  logic [23:0] addr;
  logic [TW-1:0] tmo;
  logic        tick;

  assign tick = (cnt == CW'(HALF - 1));
  assign busy = (st != ST_IDLE);
  assign mosi = tx[39];

  function automatic logic [39:0] frame(cmd_t c, logic [7:0] v, logic [23:0] a);
    case (c)
      C_WREN:  frame = {8'h06, 32'h0};
      C_WRSR:  frame = {8'h01, v, 24'h0};
      C_RDSR:  frame = {8'h05, 32'h0};
      default: frame = {8'h03, a, 8'h0};
    endcase
  endfunction

  function automatic logic [5:0] nbits(cmd_t c);
    case (c)
      C_WREN:  nbits = 6'd8;
      C_READ:  nbits = 6'd40;
      default: nbits = 6'd16;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cmd <= C_WREN; nxt <= C_WREN; more <= 1'b0; ev <= EV_NONE;
      cnt <= '0; bits <= '0; tx <= '0; rx <= '0; wval <= '0; addr <= '0; tmo <= '0;
      sck <= 1'b0; cs_n <= 1'b1; rd_data <= '0;
      wr_done <= 1'b0; wr_err <= 1'b0; rd_valid <= 1'b0;
    end else begin
      wr_done <= 1'b0; wr_err <= 1'b0; rd_valid <= 1'b0;
      if (cmd == C_RDSR && st != ST_IDLE && tmo != TW'(TMO_CYC)) tmo <= tmo + 1'b1;
      case (st)
        ST_IDLE: begin
          if (wr_start) begin
            wval <= wr_value; cmd <= C_WREN; tx <= frame(C_WREN, wr_value, addr);
            bits <= nbits(C_WREN); cs_n <= 1'b0; cnt <= '0; st <= ST_SHIFT;
          end else if (rd_start) begin
            addr <= rd_addr; cmd <= C_READ; tx <= frame(C_READ, wval, rd_addr);
            bits <= nbits(C_READ); cs_n <= 1'b0; cnt <= '0; st <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!tick) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
              rx  <= {rx[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (bits != 6'd1) begin
                bits <= bits - 1'b1;
                tx   <= {tx[38:0], 1'b0};
              end else begin
                cs_n <= 1'b1; st <= ST_GAP; more <= 1'b0; ev <= EV_NONE;
                case (cmd)
                  C_WREN: begin more <= 1'b1; nxt <= C_WRSR; end
                  C_WRSR: begin more <= 1'b1; nxt <= C_RDSR; tmo <= '0; end
                  C_RDSR: begin
                    if (!rx[0]) ev <= EV_DONE;
                    else if (tmo == TW'(TMO_CYC)) ev <= EV_ERR;
                    else begin more <= 1'b1; nxt <= C_RDSR; end
                  end
                  default: begin ev <= EV_RD; rd_data <= rx; end
                endcase
              end
            end
          end
        end
        ST_GAP: begin
          if (cnt != CW'(2 * HALF - 1)) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (more) begin
              cmd <= nxt; tx <= frame(nxt, wval, addr); bits <= nbits(nxt);
              cs_n <= 1'b0; st <= ST_SHIFT;
            end else begin
              st       <= ST_IDLE;
              wr_done  <= (ev == EV_DONE);
              wr_err   <= (ev == EV_ERR);
              rd_valid <= (ev == EV_RD);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);

  // R7
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);

  // R3 R4
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_done, wr_err, rd_valid}));

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_start || rd_start));

  if (HALF > 1) begin : g_hold
    // R6
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sck) || $fell(sck)) |=> $stable(sck));
  end

endmodule

// File: tb/sf_status_seq_tb_top.sv
`timescale 1ns/1ps
module sf_status_seq_tb_top;
  localparam int HALF = 4;
  localparam int TMO  = 2000;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, rd_start = 0, miso = 0;
  logic [7:0] wr_value = 0;
  logic [23:0] rd_addr = 0;
  logic busy, wr_done, wr_err, rd_valid, sck, cs_n, mosi;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  sf_status_seq #(.TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_value(wr_value),
    .rd_start(rd_start), .rd_addr(rd_addr), .busy(busy), .wr_done(wr_done),
    .wr_err(wr_err), .rd_valid(rd_valid), .rd_data(rd_data), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int nchk = 0, nerr = 0;
  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // flash model
  int nbit = 0, wip_left = 0, wip_cfg = 0;
  logic [39:0] sh = 0;
  logic [7:0] op_l = 0;
  logic [23:0] a_l = 0;
  realtime last_rise = 0;
  logic [39:0] q_sh[$];
  int q_n[$];

  always @(negedge cs_n) begin nbit = 0; sh = 0; op_l = 0; end
  always @(posedge sck) if (!cs_n) begin
    if (nbit > 0) chk(($realtime - last_rise) > 63.5 && ($realtime - last_rise) < 64.5,
                      "R6", "rising edge spacing ns", longint'($realtime - last_rise), 64);
    last_rise = $realtime;
    sh = {sh[38:0], mosi};
    nbit++;
    if (nbit == 8) op_l = sh[7:0];
    if (nbit == 32) a_l = sh[23:0];
  end
  always @(negedge sck) if (!cs_n) begin
    if (op_l == 8'h05 && nbit >= 8 && nbit < 16)
      miso = ({6'b0, 1'b1, wip_left > 0} >> (15 - nbit)) & 1'b1;
    else if (op_l == 8'h03 && nbit >= 32 && nbit < 40)
      miso = (mem(a_l) >> (39 - nbit)) & 1'b1;
  end
  always @(posedge cs_n) if (nbit > 0) begin
    q_sh.push_back(sh); q_n.push_back(nbit);
    if (op_l == 8'h01) wip_left = wip_cfg;
    else if (op_l == 8'h05 && wip_left > 0) wip_left--;
    nbit = 0;
  end

  // per-clock monitor
  int n_done = 0, n_err = 0, n_rv = 0, gapc = 0, cyc = 0;
  logic [7:0] rd_got = 0;
  logic prev_cs = 1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(!(cs_n && sck), "R7", "sck high while cs high", sck, 0);
      if (wr_done) n_done++;
      if (wr_err) n_err++;
      if (rd_valid) begin n_rv++; rd_got = rd_data; end
      if (!cs_n && prev_cs && gapc > 0)
        chk(gapc >= 2 * HALF, "R7", "cs high gap cycles", gapc, 2 * HALF);
      if (cs_n && busy) gapc++; else if (!cs_n) gapc = 0;
      if (!busy) gapc = 0;
      prev_cs = cs_n;
    end
    if (cyc > 190000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic clear();
    q_sh.delete(); q_n.delete(); n_done = 0; n_err = 0; n_rv = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 60000) begin @(negedge clk); n++; end
    chk(!busy, "R8", "sequence ended", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] v, int polls);
    clear(); wip_cfg = polls;
    @(negedge clk) wr_start = 1; wr_value = v;
    @(negedge clk) wr_start = 0;
    chk(busy, "R8", "busy after write request", busy, 1);
    wait_idle();
  endtask

  task automatic do_read(logic [23:0] a);
    clear();
    @(negedge clk) rd_start = 1; rd_addr = a;
    @(negedge clk) rd_start = 0;
    wait_idle();
    chk(q_n.size() == 1, "R5", "read frame count", q_n.size(), 1);
    if (q_n.size() > 0) begin
      chk(q_n[0] == 40, "R5", "read rising edges", q_n[0], 40);
      chk(q_sh[0][39:8] == {8'h03, a}, "R5", "opcode and address", q_sh[0][39:8], {8'h03, a});
    end
    chk(n_rv == 1, "R5", "rd_valid pulses", n_rv, 1);
    chk(rd_got == mem(a), "R5", "read byte", rd_got, mem(a));
  endtask

  task automatic check_write(logic [7:0] v, int polls);
    chk(q_n.size() == 3 + polls, "R3", "frame count", q_n.size(), 3 + polls);
    if (q_n.size() >= 3) begin
      chk(q_n[0] == 8 && q_sh[0][7:0] == 8'h06, "R1", "enable frame", q_sh[0][7:0], 8'h06);
      chk(q_n[1] == 16, "R2", "status write edges", q_n[1], 16);
      chk(q_sh[1][15:0] == {8'h01, v}, "R1", "status write bits", q_sh[1][15:0], {8'h01, v});
      for (int i = 2; i < q_n.size(); i++)
        chk(q_n[i] == 16 && q_sh[i][15:8] == 8'h05, "R3", "poll frame", q_sh[i][15:8], 8'h05);
    end
    chk(n_done == 1, "R3", "done pulses", n_done, 1);
    chk(n_err == 0, "R3", "error pulses", n_err, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1, "R9", "cs_n in reset", cs_n, 1);
    chk(sck === 1'b0, "R9", "sck in reset", sck, 0);
    chk(busy === 1'b0, "R9", "busy in reset", busy, 0);
    chk({wr_done, wr_err, rd_valid} === 3'b0, "R9", "pulses in reset", {wr_done, wr_err, rd_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    do_write(8'h1C, 3); check_write(8'h1C, 3);
    do_write(8'h00, 0); check_write(8'h00, 0);
    do_write(8'hFF, 1); check_write(8'hFF, 1);

    do_read(24'hABCDEF);
    do_read(24'h000001);
    do_read(24'hFFFFFE);

    // R4 timeout
    do_write(8'h3C, 1_000_000);
    chk(n_err == 1, "R4", "error pulses", n_err, 1);
    chk(n_done == 0, "R4", "done pulses", n_done, 0);
    chk(q_n.size() > 4, "R4", "polls before timeout", q_n.size(), 5);
    wip_cfg = 0; wip_left = 0;

    // R8 requests while busy are ignored
    clear();
    @(negedge clk) rd_start = 1; rd_addr = 24'h123456;
    @(negedge clk) rd_start = 0;
    repeat (20) @(negedge clk);
    wr_start = 1; rd_start = 1; rd_addr = 24'h000000;
    @(negedge clk) wr_start = 0; rd_start = 0;
    wait_idle();
    chk(q_n.size() == 1, "R8", "frames after busy requests", q_n.size(), 1);
    chk(n_done == 0 && n_rv == 1, "R8", "events after busy requests", n_done, 0);
    chk(rd_got == mem(24'h123456), "R8", "first read kept", rd_got, mem(24'h123456));

    // R8 simultaneous requests: write wins
    clear(); wip_cfg = 0;
    @(negedge clk) wr_start = 1; rd_start = 1; wr_value = 8'h44; rd_addr = 24'h777777;
    @(negedge clk) wr_start = 0; rd_start = 0;
    wait_idle();
    chk(q_n.size() > 0 && q_sh[0][7:0] == 8'h06, "R8", "write taken first", q_n.size() > 0 ? q_sh[0][7:0] : 0, 8'h06);
    chk(n_rv == 0, "R8", "read dropped", n_rv, 0);
    check_write(8'h44, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule